// File: doc/BRIEF.md
# Processor Status and Interrupt Stack Sequencer

This block holds the flag byte of an 8-bit accumulator-style processor core and runs every stack transfer that carries that byte. A hardware interrupt and a software break both save the return address and the flags to the stack and then read a two-byte jump target from the top of the address space. The push-flags and pull-flags commands move the flag byte by itself. The return-from-interrupt command restores the flags and then the return address. When reset is released, the block runs a short start-up sequence. The instruction decoder raises one-cycle command strobes and supplies the return program counter. A single-port byte memory answers the reads combinationally in the same cycle.

Bit positions 5 and 4 of the flag byte have no storage. Each push fills them in from its cause: `10` for the two hardware interrupts and `11` for the software break and for push-flags. A pull throws them away. The stack occupies page `0x01`. A push writes to `0x0100+SP` and then decrements SP. A pull increments SP first and then reads from `0x0100+SP`.

The controller uses these states. `S_RST` drops SP by three and sets I. `S_IDLE` waits for work. `S_PUSH_PCH`, `S_PUSH_PCL` and `S_PUSH_P` save the return address high byte, its low byte and the flags. `S_VEC_LO` and `S_VEC_HI` read the vector. `S_PULL_P`, `S_PULL_PCL` and `S_PULL_PCH` restore the flags and the address. `S_DONE` pulses the finish signal. The transitions are:
- `S_RST`→`S_VEC_LO`
- `S_IDLE`→`S_PUSH_PCH` on NMI, IRQ or break
- `S_IDLE`→`S_PUSH_P` on push-flags
- `S_IDLE`→`S_PULL_P` on pull-flags or return
- `S_PUSH_PCH`→`S_PUSH_PCL`→`S_PUSH_P`
- `S_PUSH_P`→`S_DONE` for push-flags, otherwise `S_PUSH_P`→`S_VEC_LO`
- `S_VEC_LO`→`S_VEC_HI`→`S_DONE`
- `S_PULL_P`→`S_PULL_PCL` for return, otherwise `S_PULL_P`→`S_DONE`
- `S_PULL_PCL`→`S_PULL_PCH`→`S_DONE`
- `S_DONE`→`S_IDLE`

Top module: `status_irq_seq`

## Requirements
- R1: After reset is released, the block performs no stack write and drops SP by 3 (from 0x00 to 0xFD). It sets I (status bit 2) and reads 0xFFFC and then 0xFFFD. `done_o` then pulses and `pc_o` holds {byte@FFFD, byte@FFFC}.
- R2: A break, IRQ or NMI writes the latched return PC high byte at 0x0100+SP, then its low byte at 0x0100+SP-1, then the flag byte at 0x0100+SP-2. SP ends 3 lower.
- R3: The pushed flag byte carries stored N, V, D, I, Z and C at bits 7, 6, 3, 2, 1 and 0. Bits 5:4 are `11` for break and push-flags and `10` for IRQ and NMI. Push-flags writes one byte, lowers SP by 1 and changes no flag.
- R4: Break, IRQ and NMI set I, and it reads as 1 from the first vector-read cycle onward.
- R5: The vector is read low byte first and then high byte, from 0xFFFA/0xFFFB for NMI and from 0xFFFE/0xFFFF for IRQ and break. `done_o` is high for exactly one cycle, and `pc_o` changes only in that cycle.
- R6: Pull-flags increments SP, reads 0x0100+SP and loads bits 7, 6, 3, 2, 1 and 0. `status_o` bits 5:4 always read 0.
- R7: Return-from-interrupt pulls the flags, then the low PC byte, then the high PC byte from three rising addresses. SP ends 3 higher and `pc_o` holds the pulled address at the done pulse.
- R8: NMI (`nmi_n`) is taken on a falling edge. An edge that arrives while the block is busy is kept until the block is idle. Holding the pin low does not take it again.
- R9: IRQ (`irq_n` low) is level sensitive and is ignored while I is 1. It is taken as soon as I clears while the pin is still low.
- R10: In `S_IDLE` the order of priority is pending NMI, unmasked IRQ, break, push-flags, pull-flags, return. A strobe that loses to another request, or that arrives while the block is busy, is dropped.
- R11: The D flag (bit 3) is stored and comes back unchanged through a pull and a later push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the start-up sequence runs when it is released |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge triggered |
| irq_n | input | 1 | Maskable interrupt, active low |
| cmd_php | input | 1 | Push-flags strobe |
| cmd_plp | input | 1 | Pull-flags strobe |
| cmd_brk | input | 1 | Software break strobe |
| cmd_rti | input | 1 | Return-from-interrupt strobe |
| ret_pc_i | input | 16 | Return address, latched when a sequence starts |
| mem_addr_o | output | 16 | Stack or vector address |
| mem_wdata_o | output | 8 | Stack write data |
| mem_we_o | output | 1 | Stack write enable |
| mem_rdata_i | input | 8 | Read data for the current address |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Flag byte, bits 5:4 read as 0 |
| pc_o | output | 16 | New program counter, valid from the done pulse onward |
| done_o | output | 1 | One-cycle finish pulse |

## Verification
The case that needs care is an NMI edge, a held IRQ and a break strobe all competing for the same idle cycle. The bench causes it by lowering `nmi_n` and `irq_n` while a push-flags sequence is running and holding `cmd_brk` until the block goes idle. The edge is latched while the block is busy, so all three requests meet in one `S_IDLE` cycle. The reference model must then expect pushes with bits 5:4 = `10`, vector reads at 0xFFFA and 0xFFFB, and a dropped break. Two other coincidences are also driven: a return that clears I while IRQ is held low, which chains straight into an IRQ entry, and two command strobes raised in the same cycle.

// File: rtl/sis_pkg.sv
package sis_pkg;

    typedef enum logic [3:0] {
        S_RST,
        S_IDLE,
        S_PUSH_PCH,
        S_PUSH_PCL,
        S_PUSH_P,
        S_VEC_LO,
        S_VEC_HI,
        S_PULL_P,
        S_PULL_PCL,
        S_PULL_PCH,
        S_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        K_RESET,
        K_NMI,
        K_IRQ,
        K_BRK,
        K_PHP,
        K_PLP,
        K_RTI
    } seq_kind_t;

    // index of the interrupt mask inside the 6-bit stored flag vector {N,V,D,I,Z,C}
    localparam int FL_I = 2;

endpackage

// File: rtl/sis_flags.sv
module sis_flags
    import sis_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_en,
    input  logic [5:0] load_bits,   // {N,V,D,I,Z,C} taken from a pulled byte
    input  logic       set_i,
    input  logic       soft_push,   // 1: break / push-flags, 0: hardware interrupt
    output logic [7:0] push_byte,
    output logic [7:0] status_o,
    output logic       flag_i
);

    logic [5:0] fl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else if (load_en) begin
            fl_q <= load_bits;
        end else if (set_i) begin
            fl_q[FL_I] <= 1'b1;
        end
    end

    always_comb begin
        push_byte = {fl_q[5:4], 1'b1, soft_push, fl_q[3:0]};
        status_o  = {fl_q[5:4], 2'b00, fl_q[3:0]};
        flag_i    = fl_q[FL_I];
    end

    // R4: a mask-set request is visible on the next cycle
    p_i_after_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !load_en) |=> flag_i);

endmodule

// File: rtl/sis_int_detect.sv
module sis_int_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic irq_n,
    input  logic flag_i,
    input  logic nmi_ack,
    output logic nmi_req,
    output logic irq_req
);

    logic nmi_prev_q;
    logic nmi_pend_q;
    logic nmi_fall;

    assign nmi_fall = nmi_prev_q & ~nmi_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b1;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_n;
            nmi_pend_q <= nmi_fall | (nmi_pend_q & ~nmi_ack);
        end
    end

    assign nmi_req = nmi_pend_q;
    assign irq_req = ~irq_n & ~flag_i;

    // R8: a falling edge is always remembered
    p_nmi_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_fall |=> nmi_req);

    // R8: taking the NMI consumes it unless a fresh edge arrives together
    p_nmi_consume_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_ack && !nmi_fall) |=> !nmi_req);

endmodule

// File: rtl/status_irq_seq.sv
module status_irq_seq
    import sis_pkg::*;
#(
    parameter int            AW          = 16,
    parameter int            DW          = 8,
    parameter logic [DW-1:0] STACK_PAGE  = 8'h01,
    parameter logic [AW-1:0] NMI_VEC     = 16'hFFFA,
    parameter logic [AW-1:0] RST_VEC     = 16'hFFFC,
    parameter logic [AW-1:0] IRQ_VEC     = 16'hFFFE,
    parameter int            RST_SP_DROP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_n,
    input  logic          irq_n,
    input  logic          cmd_php,
    input  logic          cmd_plp,
    input  logic          cmd_brk,
    input  logic          cmd_rti,
    input  logic [AW-1:0] ret_pc_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          mem_we_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [DW-1:0] sp_o,
    output logic [DW-1:0] status_o,
    output logic [AW-1:0] pc_o,
    output logic          done_o
);

    seq_state_t    state_q, state_d;
    seq_kind_t     kind_q, kind_d;
    logic [DW-1:0] sp_q, sp_inc, pcl_q;
    logic [AW-1:0] pc_q, ret_q, vec_base;
    logic          nmi_req, irq_req, nmi_ack, flag_i;
    logic          fl_load, fl_set_i, soft_push;
    logic [DW-1:0] push_byte;

    assign sp_inc = sp_q + 1'b1;

    sis_int_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .irq_n   (irq_n),
        .flag_i  (flag_i),
        .nmi_ack (nmi_ack),
        .nmi_req (nmi_req),
        .irq_req (irq_req)
    );

    assign fl_load   = (state_q == S_PULL_P);
    assign fl_set_i  = ((state_q == S_PUSH_P) && (kind_q != K_PHP)) || (state_q == S_RST);
    assign soft_push = (kind_q == K_BRK) || (kind_q == K_PHP);

    sis_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (fl_load),
        .load_bits ({mem_rdata_i[7:6], mem_rdata_i[3:0]}),
        .set_i     (fl_set_i),
        .soft_push (soft_push),
        .push_byte (push_byte),
        .status_o  (status_o),
        .flag_i    (flag_i)
    );

    // next state and request arbitration
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        nmi_ack = 1'b0;
        unique case (state_q)
            S_RST:      state_d = S_VEC_LO;
            S_IDLE: begin
                if (nmi_req) begin
                    state_d = S_PUSH_PCH; kind_d = K_NMI; nmi_ack = 1'b1;
                end else if (irq_req) begin
                    state_d = S_PUSH_PCH; kind_d = K_IRQ;
                end else if (cmd_brk) begin
                    state_d = S_PUSH_PCH; kind_d = K_BRK;
                end else if (cmd_php) begin
                    state_d = S_PUSH_P;   kind_d = K_PHP;
                end else if (cmd_plp) begin
                    state_d = S_PULL_P;   kind_d = K_PLP;
                end else if (cmd_rti) begin
                    state_d = S_PULL_P;   kind_d = K_RTI;
                end
            end
            S_PUSH_PCH: state_d = S_PUSH_PCL;
            S_PUSH_PCL: state_d = S_PUSH_P;
            S_PUSH_P:   state_d = (kind_q == K_PHP) ? S_DONE : S_VEC_LO;
            S_VEC_LO:   state_d = S_VEC_HI;
            S_VEC_HI:   state_d = S_DONE;
            S_PULL_P:   state_d = (kind_q == K_RTI) ? S_PULL_PCL : S_DONE;
            S_PULL_PCL: state_d = S_PULL_PCH;
            S_PULL_PCH: state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RST;
            kind_q  <= K_RESET;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
        end
    end

    // stack pointer, return latch, vector assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q  <= '0;
            pcl_q <= '0;
            pc_q  <= '0;
            ret_q <= '0;
        end else begin
            if ((state_q == S_IDLE) && (state_d != S_IDLE)) ret_q <= ret_pc_i;
            case (state_q)
                S_RST:      sp_q <= sp_q - DW'(RST_SP_DROP);
                S_PUSH_PCH,
                S_PUSH_PCL,
                S_PUSH_P:   sp_q <= sp_q - 1'b1;
                S_PULL_P:   sp_q <= sp_inc;
                S_PULL_PCL: begin
                    sp_q  <= sp_inc;
                    pcl_q <= mem_rdata_i;
                end
                S_PULL_PCH: begin
                    sp_q <= sp_inc;
                    pc_q <= AW'({mem_rdata_i, pcl_q});
                end
                S_VEC_LO:   pcl_q <= mem_rdata_i;
                S_VEC_HI:   pc_q  <= AW'({mem_rdata_i, pcl_q});
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (kind_q)
            K_NMI:   vec_base = NMI_VEC;
            K_RESET: vec_base = RST_VEC;
            default: vec_base = IRQ_VEC;
        endcase
    end

    // outputs per state
    always_comb begin
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        mem_we_o    = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            S_PUSH_PCH: begin
                mem_we_o = 1'b1; mem_addr_o = AW'({STACK_PAGE, sp_q}); mem_wdata_o = ret_q[AW-1:DW];
            end
            S_PUSH_PCL: begin
                mem_we_o = 1'b1; mem_addr_o = AW'({STACK_PAGE, sp_q}); mem_wdata_o = ret_q[DW-1:0];
            end
            S_PUSH_P: begin
                mem_we_o = 1'b1; mem_addr_o = AW'({STACK_PAGE, sp_q}); mem_wdata_o = push_byte;
            end
            S_VEC_LO:   mem_addr_o = vec_base;
            S_VEC_HI:   mem_addr_o = vec_base + 1'b1;
            S_PULL_P,
            S_PULL_PCL,
            S_PULL_PCH: mem_addr_o = AW'({STACK_PAGE, sp_inc});
            S_DONE:     done_o = 1'b1;
            default:    ;
        endcase
    end

    assign sp_o = sp_q;
    assign pc_o = pc_q;

    // R2: every write goes to the stack page
    p_stack_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o[AW-1:DW] == STACK_PAGE));

    // R2: every write is followed by a decremented pointer
    p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (sp_o == DW'($past(sp_o) - 1'b1)));

    // R5: high vector byte is read right after the low one
    p_vec_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_VEC_HI) |-> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

    // R5: done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5 / R7: the program counter moves only with done
    p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(pc_o));

    // R6: a pull cycle raises the pointer by one
    p_pull_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PULL_P) |=> (sp_o == DW'($past(sp_o) + 1'b1)));

endmodule

// File: tb/status_irq_seq_tb.sv
module status_irq_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_n = 1'b1, irq_n = 1'b1;
    logic        cmd_php = 1'b0, cmd_plp = 1'b0, cmd_brk = 1'b0, cmd_rti = 1'b0;
    logic [15:0] ret_pc = 16'h0000;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata, sp, status;
    logic        mem_we, done;
    logic [15:0] pc;

    always #10 clk = ~clk;   // 50 MHz

    status_irq_seq u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .cmd_php(cmd_php), .cmd_plp(cmd_plp), .cmd_brk(cmd_brk), .cmd_rti(cmd_rti),
        .ret_pc_i(ret_pc), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_we_o(mem_we), .mem_rdata_i(mem_rdata), .sp_o(sp), .status_o(status),
        .pc_o(pc), .done_o(done)
    );

    // environment memory: one stack page plus the vector bytes
    logic [7:0] stk [256];

    function automatic logic [7:0] vb(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h11;
            16'hFFFB: return 8'h8A;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'hC0;
            16'hFFFE: return 8'h55;
            16'hFFFF: return 8'hE3;
            default:  return 8'h00;
        endcase
    endfunction

    assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] : vb(mem_addr);

    always @(posedge clk) if (rst_n && mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

    // reference model: queue of expected per-cycle outputs
    typedef struct {
        bit          we;
        bit          chk_addr;
        logic [15:0] addr;
        logic [7:0]  wd;
        bit          dn;
        logic [15:0] pcv;
        logic [7:0]  spv;
        logic [7:0]  st;
        string       tag;
    } exp_t;

    exp_t        q[$];
    exp_t        e;
    logic [7:0]  m_sp, m_st;
    logic [15:0] m_pc;
    bit          m_pend, m_prev, was_idle, took, fall;
    int          checks = 0, errors = 0, cyc = 0;

    task automatic add(bit we, bit ca, logic [15:0] a, logic [7:0] wd, bit dn,
                       logic [15:0] pcv, logic [7:0] spv, logic [7:0] st, string tag);
        exp_t x;
        x.we = we; x.chk_addr = ca; x.addr = a; x.wd = wd; x.dn = dn;
        x.pcv = pcv; x.spv = spv; x.st = st; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic sched_int(logic [15:0] vec, logic [7:0] bfix, string tag);
        logic [7:0]  s = m_sp, f = m_st;
        logic [15:0] r = ret_pc;
        logic [15:0] nv = {vb(vec + 16'd1), vb(vec)};
        add(1, 1, {8'h01, s},          r[15:8],  0, 0, s,          f, tag);
        add(1, 1, {8'h01, 8'(s - 1)}, r[7:0],   0, 0, 8'(s - 1), f, tag);
        add(1, 1, {8'h01, 8'(s - 2)}, f | bfix, 0, 0, 8'(s - 2), f, "R3");
        add(0, 1, vec,                 0, 0, 0, 8'(s - 3), f | 8'h04, "R4");
        add(0, 1, vec + 16'd1,         0, 0, 0, 8'(s - 3), f | 8'h04, "R5");
        add(0, 0, 0,                   0, 1, nv, 8'(s - 3), f | 8'h04, "R5");
        m_sp = 8'(s - 3); m_st = f | 8'h04; m_pc = nv;
    endtask

    task automatic sched_php();
        logic [7:0] s = m_sp, f = m_st;
        add(1, 1, {8'h01, s}, f | 8'h30, 0, 0, s, f, "R3");
        add(0, 0, 0, 0, 1, m_pc, 8'(s - 1), f, "R3");
        m_sp = 8'(s - 1);
    endtask

    task automatic sched_pull(bit rti);
        logic [7:0] s = m_sp, f = m_st;
        logic [7:0] nf = stk[8'(s + 1)] & 8'hCF;
        logic [7:0] lo = stk[8'(s + 2)], hi = stk[8'(s + 3)];
        if (!rti) begin
            add(0, 1, {8'h01, 8'(s + 1)}, 0, 0, 0, s, f, "R6");
            add(0, 0, 0, 0, 1, m_pc, 8'(s + 1), nf, "R6");
            m_sp = 8'(s + 1);
        end else begin
            add(0, 1, {8'h01, 8'(s + 1)}, 0, 0, 0, s,          f,  "R7");
            add(0, 1, {8'h01, 8'(s + 2)}, 0, 0, 0, 8'(s + 1), nf, "R7");
            add(0, 1, {8'h01, 8'(s + 3)}, 0, 0, 0, 8'(s + 2), nf, "R7");
            add(0, 0, 0, 0, 1, {hi, lo}, 8'(s + 3), nf, "R7");
            m_sp = 8'(s + 3); m_pc = {hi, lo};
        end
        m_st = nf;
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_sp = 8'h00; m_st = 8'h00; m_pc = 16'h0000;
            m_pend = 0; m_prev = 1; was_idle = 0;
            chk(mem_we === 1'b0 && done === 1'b0, "R1", "reset outputs", {mem_we, done}, 0);
            add(0, 0, 0,        0, 0, 0, 8'h00, 8'h00, "R1");
            add(0, 1, 16'hFFFC, 0, 0, 0, 8'hFD, 8'h04, "R1");
            add(0, 1, 16'hFFFD, 0, 0, 0, 8'hFD, 8'h04, "R1");
            add(0, 0, 0,        0, 1, 16'hC000, 8'hFD, 8'h04, "R1");
            m_sp = 8'hFD; m_st = 8'h04; m_pc = 16'hC000;
        end else begin
            if (q.size() > 0) begin
                e = q.pop_front();
                was_idle = 0;
            end else begin
                e.we = 0; e.chk_addr = 0; e.addr = 0; e.wd = 0; e.dn = 0;
                e.pcv = m_pc; e.spv = m_sp; e.st = m_st; e.tag = "R10";
                was_idle = 1;
            end
            chk(mem_we === e.we, e.tag, "we", 32'(mem_we), 32'(e.we));
            if (e.we || e.chk_addr) chk(mem_addr === e.addr, e.tag, "addr", 32'(mem_addr), 32'(e.addr));
            if (e.we) chk(mem_wdata === e.wd, e.tag, "wdata", 32'(mem_wdata), 32'(e.wd));
            chk(done === e.dn, e.tag, "done", 32'(done), 32'(e.dn));
            if (e.dn || was_idle) chk(pc === e.pcv, e.tag, "pc", 32'(pc), 32'(e.pcv));
            chk(sp === e.spv, e.tag, "sp", 32'(sp), 32'(e.spv));
            chk(status === e.st, e.tag, "status", 32'(status), 32'(e.st));
        end
    end

    // model decisions at the active edge
    always @(posedge clk) begin
        if (rst_n) begin
            fall = m_prev && !nmi_n;
            took = 0;
            if (was_idle) begin
                if (m_pend) begin
                    sched_int(16'hFFFA, 8'h20, "R8"); took = 1;
                end else if (!irq_n && !m_st[2]) sched_int(16'hFFFE, 8'h20, "R9");
                else if (cmd_brk) sched_int(16'hFFFE, 8'h30, "R2");
                else if (cmd_php) sched_php();
                else if (cmd_plp) sched_pull(0);
                else if (cmd_rti) sched_pull(1);
            end
            m_pend = fall || (m_pend && !took);
            m_prev = nmi_n;
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        step(3);
        rst_n = 1'b1;                 // R1 start-up sequence
        step(10);
        stk[8'(m_sp + 1)] = 8'hFF;    // R6 / R11: all flags including D
        cmd_plp = 1; step(1); cmd_plp = 0; step(6);
        cmd_php = 1; step(1); cmd_php = 0; step(6);   // R3 / R11
        stk[8'(m_sp + 1)] = 8'h30;    // R6: bits 5:4 discarded
        cmd_plp = 1; step(1); cmd_plp = 0; step(6);
        ret_pc = 16'h1234;
        cmd_brk = 1; step(1); cmd_brk = 0; step(10);  // R2 R3 R4 R5
        irq_n = 0; step(8);                           // R9 masked
        cmd_php = 1; step(1); cmd_php = 0; step(1);   // R10: strobes while busy
        cmd_plp = 1; step(1); cmd_plp = 0; step(6);
        stk[8'(m_sp + 1)] = 8'h30; stk[8'(m_sp + 2)] = 8'h34; stk[8'(m_sp + 3)] = 8'h12;
        ret_pc = 16'h4321;
        cmd_rti = 1; step(1); cmd_rti = 0; step(14);  // R7 then R9 chain
        irq_n = 1; step(4);
        nmi_n = 0; step(12);                          // R8
        step(8);                                      // held low: no repeat
        nmi_n = 1; step(3);
        cmd_php = 1; step(1); cmd_php = 0;            // R8 / R10 coincidence
        nmi_n = 0; irq_n = 0; cmd_brk = 1; step(3); cmd_brk = 0; step(12);
        nmi_n = 1; irq_n = 1; step(3);
        stk[8'(m_sp + 1)] = 8'h08;
        cmd_plp = 1; cmd_rti = 1; step(1); cmd_plp = 0; cmd_rti = 0; step(6);  // R10 order, R11 D
        cmd_php = 1; step(1); cmd_php = 0; step(6);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule